// File: doc/BRIEF.md
# Dual-Modulus Pulse-Swallow Frequency Divider

This block performs the counting of a pulse-swallow RF frequency divider. It runs on the RF input clock. A prescaler divides that clock by 9 or by 8. Two counters steer it: a 3-bit swallow count A and an 11-bit main count M. One full divide cycle is M prescaler periods. The first A of those periods are 9 clocks long and the rest are 8 clocks long. The total ratio is therefore 8·M + A input clocks, and the supported range is 56 to 16383.

The ratio comes from a static 14-bit bus. There is no load strobe. At board level, an unconnected bus bit reads as 1, so an all-ones bus selects the largest ratio. The bus is sampled only at the end of each divide cycle and during reset, so a change never breaks a cycle that is in progress. At the start of every divide cycle the block produces one output pulse, exactly one prescaler base period (8 clocks) long. An enable input can suppress that pulse. A status output flags ratio words that a pulse-swallow arrangement cannot realise.

Top module: `pulse_swallow_div`

## Requirements
- R1: Successive rising edges of `div_pulse` are 8·M + A clocks apart, with M = `ratio_bus[13:3]` and A = `ratio_bus[2:0]`. The first A prescaler periods of a cycle last 9 clocks and the remaining ones last 8 clocks.
- R2: Every pulse on `div_pulse` is high for exactly 8 consecutive clocks, including cycles that begin with a 9-clock period.
- R3: The A field is bus bits [2:0] and the M field is bus bits [13:3]. Each field is read as an unsigned binary number.
- R4: A bus value that changes partway through a divide cycle does not alter that cycle. It takes effect from the next cycle on.
- R5: While `out_en` is low, `div_pulse` stays low. `div_pulse` uses the value of `out_en` registered one clock earlier, so raising `out_en` outside the pulse window gives full-width pulses from the next cycle onward.
- R6: `ratio_bad` is 1 exactly when the latched M < A or M < 7. It changes only when the ratio is latched, that is in reset or at the end of a cycle. The counters keep running while it is 1.
- R7: A synchronous active-high `rst` clears both counters and latches the bus. The first clock after reset is the first clock of a new divide cycle, and on that clock `div_pulse` equals `out_en`.
- R8: An all-ones bus (M = 2047, A = 7) gives a ratio of 16383.
- R9: The minimum valid word (M = 7, A = 0) gives a ratio of 56.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | RF input clock |
| rst | input | 1 | Synchronous active-high reset |
| ratio_bus | input | 14 | Static ratio word: [13:3] main count M, [2:0] swallow count A |
| out_en | input | 1 | High enables the output pulse |
| div_pulse | output | 1 | Registered divider output pulse, 8 clocks wide |
| ratio_bad | output | 1 | Latched ratio has M < A or M < 7 |

## Verification
The assertions assume that `rst` is high for at least one clock at start-up. They also assume that the latched ratio is valid whenever the pulse window and the period sequence are judged. With an invalid word the counters still step, but they no longer produce 8·M + A.

The stimulus changes `ratio_bus` and `out_en` only one nanosecond after a rising edge. A ratio change is made well inside a cycle. `out_en` is raised only outside the 8-clock pulse window. Invalid words are applied only with the output disabled, and the test then observes nothing but the status bit.

// File: rtl/psd_pkg.sv
package psd_pkg;
  localparam int unsigned DEF_A_W     = 3;
  localparam int unsigned DEF_M_W     = 11;
  localparam int unsigned DEF_PRE_DIV = 8;

  typedef enum logic {
    MOD_LO = 1'b0,
    MOD_HI = 1'b1
  } modulus_e;
endpackage

// File: rtl/psd_ratio_latch.sv
module psd_ratio_latch #(
  parameter int unsigned A_W   = 3,
  parameter int unsigned M_W   = 11,
  parameter int unsigned MIN_M = 7
) (
  input  logic             clk,
  input  logic             rst,
  input  logic             load,
  input  logic [A_W+M_W-1:0] bus,
  output logic [A_W-1:0]   a_r,
  output logic [M_W-1:0]   m_r,
  output logic             bad
);
  logic [A_W-1:0] a_in;
  logic [M_W-1:0] m_in;
  logic [M_W-1:0] a_ext;
  logic           bad_in;

  always_comb begin
    a_in   = bus[A_W-1:0];
    m_in   = bus[A_W +: M_W];
    a_ext  = {{(M_W-A_W){1'b0}}, a_in};
    bad_in = (m_in < a_ext) || (m_in < M_W'(MIN_M));
  end

  always_ff @(posedge clk) begin
    if (load) begin
      a_r <= a_in;
      m_r <= m_in;
      bad <= bad_in;
    end
  end

  // R4 / R6: latched ratio and status move only on a load
  p_hold_r4: assert property (@(posedge clk) disable iff (rst)
    !load |=> ($stable(a_r) && $stable(m_r) && $stable(bad)));
endmodule

// File: rtl/psd_prescaler.sv
module psd_prescaler
  import psd_pkg::*;
#(
  parameter int unsigned PRE_DIV = 8,
  parameter int unsigned CW      = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  modulus_e      mode,
  output logic [CW-1:0] cnt,
  output logic          tc
);
  logic [CW-1:0] last;

  always_comb begin
    last = (mode == MOD_HI) ? CW'(PRE_DIV) : CW'(PRE_DIV - 1);
    tc   = (cnt == last);
  end

  always_ff @(posedge clk) begin
    if (rst || tc) cnt <= '0;
    else           cnt <= cnt + 1'b1;
  end

  // R1: the extra (ninth) clock exists only in the high modulus
  p_hi_only_r1: assert property (@(posedge clk) disable iff (rst)
    (cnt == CW'(PRE_DIV)) |-> (mode == MOD_HI));
endmodule

// File: rtl/psd_cycle_ctr.sv
module psd_cycle_ctr
  import psd_pkg::*;
#(
  parameter int unsigned A_W = 3,
  parameter int unsigned M_W = 11
) (
  input  logic           clk,
  input  logic           rst,
  input  logic           tc,
  input  logic [A_W-1:0] a_r,
  input  logic [M_W-1:0] m_r,
  output modulus_e       mode,
  output logic           cyc_end,
  output logic           first_per
);
  logic [A_W-1:0] a_cnt;
  logic [M_W-1:0] m_cnt;
  logic [M_W-1:0] m_inc;

  always_comb begin
    m_inc     = m_cnt + 1'b1;
    mode      = (a_cnt < a_r) ? MOD_HI : MOD_LO;
    cyc_end   = tc && (m_inc == m_r);
    first_per = (m_cnt == '0);
  end

  always_ff @(posedge clk) begin
    if (rst || cyc_end) begin
      a_cnt <= '0;
      m_cnt <= '0;
    end else if (tc) begin
      m_cnt <= m_inc;
      if (mode == MOD_HI) a_cnt <= a_cnt + 1'b1;
    end
  end

  // R1: swallow count never passes the latched A
  p_a_bound_r1: assert property (@(posedge clk) disable iff (rst)
    a_cnt <= a_r);
  // R1: all nine-clock periods come first in the cycle
  p_swallow_first_r1: assert property (@(posedge clk) disable iff (rst)
    (mode == MOD_HI) |-> (m_cnt == {{(M_W-A_W){1'b0}}, a_cnt}));
endmodule

// File: rtl/psd_pulse_gen.sv
module psd_pulse_gen #(
  parameter int unsigned PRE_DIV = 8,
  parameter int unsigned CW      = 4
) (
  input  logic          clk,
  input  logic          rst,
  input  logic          en,
  input  logic          cyc_end,
  input  logic          first_per,
  input  logic          tc,
  input  logic [CW-1:0] pre_cnt,
  output logic          pulse
);
  logic win_next;

  always_comb begin
    win_next = rst || cyc_end ||
               (first_per && !tc && (pre_cnt < CW'(PRE_DIV - 1)));
  end

  always_ff @(posedge clk) begin
    pulse <= en && win_next;
  end

  // R5: a low enable one clock earlier keeps the output low
  p_gate_r5: assert property (@(posedge clk) disable iff (rst)
    !$past(en) |-> !pulse);
  // R2: pulse sits inside the first base period of a cycle
  p_window_r2: assert property (@(posedge clk) disable iff (rst)
    pulse |-> (first_per && (pre_cnt < CW'(PRE_DIV))));
endmodule

// File: rtl/pulse_swallow_div.sv
module pulse_swallow_div
  import psd_pkg::*;
#(
  parameter int unsigned A_W     = DEF_A_W,
  parameter int unsigned M_W     = DEF_M_W,
  parameter int unsigned PRE_DIV = DEF_PRE_DIV
) (
  input  logic               clk,
  input  logic               rst,
  input  logic [A_W+M_W-1:0] ratio_bus,
  input  logic               out_en,
  output logic               div_pulse,
  output logic               ratio_bad
);
  localparam int unsigned CW    = $clog2(PRE_DIV + 1);
  localparam int unsigned MIN_M = PRE_DIV - 1;

  logic [A_W-1:0] a_r;
  logic [M_W-1:0] m_r;
  logic [CW-1:0]  pre_cnt;
  logic           tc;
  logic           cyc_end;
  logic           first_per;
  logic           load;
  modulus_e       mode;

  assign load = rst || cyc_end;

  psd_ratio_latch #(.A_W(A_W), .M_W(M_W), .MIN_M(MIN_M)) u_latch (
    .clk(clk), .rst(rst), .load(load), .bus(ratio_bus),
    .a_r(a_r), .m_r(m_r), .bad(ratio_bad)
  );

  psd_prescaler #(.PRE_DIV(PRE_DIV), .CW(CW)) u_pre (
    .clk(clk), .rst(rst), .mode(mode), .cnt(pre_cnt), .tc(tc)
  );

  psd_cycle_ctr #(.A_W(A_W), .M_W(M_W)) u_cyc (
    .clk(clk), .rst(rst), .tc(tc), .a_r(a_r), .m_r(m_r),
    .mode(mode), .cyc_end(cyc_end), .first_per(first_per)
  );

  psd_pulse_gen #(.PRE_DIV(PRE_DIV), .CW(CW)) u_pulse (
    .clk(clk), .rst(rst), .en(out_en), .cyc_end(cyc_end),
    .first_per(first_per), .tc(tc), .pre_cnt(pre_cnt), .pulse(div_pulse)
  );

  // R7: the clock after reset opens a cycle at prescaler count zero
  p_reset_start_r7: assert property (@(posedge clk)
    rst |=> (first_per && (pre_cnt == '0)));
endmodule

// File: tb/pulse_swallow_div_tb.sv
`timescale 1ns/100ps
module pulse_swallow_div_tb;
  logic        clk = 1'b0;
  logic        rst = 1'b1;
  logic [13:0] bus = '0;
  logic        en  = 1'b0;
  logic        pulse, bad;

  always #2.5 clk = ~clk;

  pulse_swallow_div u_dut (
    .clk(clk), .rst(rst), .ratio_bus(bus), .out_en(en),
    .div_pulse(pulse), .ratio_bad(bad)
  );

  typedef struct { int rise; string req; } item_t;
  item_t q[$];
  int k = 0;
  int checks = 0, fails = 0;
  int nstart = 0, last_rise = 0;

  always @(posedge clk) begin
    if (rst) k <= 0;
    else     k <= k + 1;
  end

  function automatic void chk(string r, int act, int exp);
    checks++;
    if (act != exp) begin
      fails++;
      $display("FAIL %s: actual %0d expected %0d (k=%0d)", r, act, exp, k);
    end
  endfunction

  // monitor: measure each pulse and compare with the scoreboard
  logic inp = 1'b0;
  int rise_k = 0, w = 0;
  always @(negedge clk) begin
    if (rst) inp = 1'b0;
    else if (pulse) begin
      if (!inp) begin inp = 1'b1; rise_k = k; w = 1; end
      else w++;
    end else if (inp) begin
      inp = 1'b0;
      if (q.size() == 0) chk("R5 unexpected pulse rise", rise_k, -1);
      else begin
        item_t it;
        it = q.pop_front();
        chk(it.req, rise_k, it.rise);
        chk("R2 pulse width", w, 8);
      end
    end
  end

  task automatic wait_k(int t);
    @(posedge clk); #1;
    while (k < t) begin @(posedge clk); #1; end
  endtask

  task automatic session(int m, int a, bit e, bit exp_bad);
    @(posedge clk); #1;
    rst = 1'b1; bus = {m[10:0], a[2:0]}; en = e;
    @(posedge clk); @(posedge clk); #1;
    rst = 1'b0; nstart = 0;
    @(negedge clk); #0.1;
    chk("R7 output on first clock after reset", int'(pulse), int'(e));
    chk("R6 status after reset", int'(bad), int'(exp_bad));
  endtask

  task automatic expect_n(int m, int a, int cnt, string r);
    for (int i = 0; i < cnt; i++) begin
      q.push_back('{nstart, r});
      last_rise = nstart;
      nstart += 8 * m + a;
    end
  endtask

  task automatic drain();
    wait_k(last_rise + 12);
    chk("R1 pulses still pending", q.size(), 0);
    q.delete();
  endtask

  task automatic report();
    $display("  == %0d vectors applied, %0d miscompares ==", checks, fails);
    $finish;
  endtask

  initial begin
    #(5.0 * 190000);
    checks++; fails++;
    $display("FAIL watchdog: actual timeout expected completion");
    report();
  end

  initial begin
    repeat (3) @(posedge clk);
    // R9 minimum ratio 56
    session(7, 0, 1'b1, 1'b0);
    expect_n(7, 0, 4, "R9 ratio 56 spacing");
    drain();
    // R2 width with nine-clock first periods, ratio 63
    session(7, 7, 1'b1, 1'b0);
    expect_n(7, 7, 3, "R2 ratio 63 spacing");
    drain();
    // R3 field positions: M=12, A=4 -> 100
    session(12, 4, 1'b1, 1'b0);
    expect_n(12, 4, 3, "R3 fields M=12 A=4");
    drain();
    // R1 ratio 1000
    session(125, 0, 1'b1, 1'b0);
    expect_n(125, 0, 3, "R1 ratio 1000 spacing");
    drain();
    // R4 mid-cycle change 163 -> 245
    session(20, 3, 1'b1, 1'b0);
    expect_n(20, 3, 2, "R4 old ratio kept");
    wait_k(163 + 20);
    bus = {11'd30, 3'd5};
    expect_n(30, 5, 3, "R4 new ratio from next cycle");
    drain();
    // R8 all-ones bus
    session(2047, 7, 1'b1, 1'b0);
    expect_n(2047, 7, 2, "R8 ratio 16383");
    drain();
    // R5 enable off, then on outside the window
    session(10, 1, 1'b0, 1'b0);
    wait_k(81 * 3 + 20);
    chk("R5 output low while disabled", int'(pulse), 0);
    en = 1'b1;
    nstart = 81 * 4;
    expect_n(10, 1, 2, "R5 pulses after enable");
    drain();
    // R6 invalid words, output disabled
    session(6, 0, 1'b0, 1'b1);
    session(3, 5, 1'b0, 1'b1);
    session(8, 0, 1'b0, 1'b0);
    wait_k(10);
    bus = {11'd5, 3'd0};
    wait_k(20);
    @(negedge clk);
    chk("R6 status held mid-cycle", int'(bad), 0);
    wait_k(70);
    @(negedge clk);
    chk("R6 status after cycle end", int'(bad), 1);
    report();
  end
endmodule